// File: doc/BRIEF.md
# Second-Order Recursive Filter Section with Quantizer Error Feedback

This block is a fixed-point second-order IIR section. Its recursion is arranged in transposed direct form I. The input sample is added to the delayed feedback partial sum, which gives one internal node value. That single node drives one constant-multiplier block. The block forms all five coefficient products (three numerator, two denominator) from one shared set of shifted copies, using only adders and subtractors. The products then flow into two short chains of delay registers: one chain for the feedback sums and one for the output sums.

Coefficients are signed integers that carry `FB` fractional bits. Sums are kept at full precision. A quantizer brings the node sum and the output sum back to the data width. Its mode is chosen by a parameter: magnitude truncation (toward zero) or rounding (half up). The error the quantizer leaves on the node is kept for two samples. It is scaled by two power-of-two weights and added back into the next node sum. This error feedback, together with magnitude truncation, drives the section to an exact zero once the input goes quiet.

Samples arrive with a valid strobe. Each valid sample advances the filter by one step, and the result appears on the output one clock later.

Top module: `iirEfSection`

## Requirements
- R1: For each valid sample x, the section computes accV = x·2^FB + s1 + ef and v = Q(accV) saturated, then accY = B0·v + t1 and y = Q(accY) saturated. The state then updates as s1 ← s2 − A1·v, s2 ← −A2·v, t1 ← t2 + B1·v, t2 ← B2·v. The output equals this difference equation bit for bit.
- R2: In magnitude-truncation mode (QMODE = QM_MAGTRUNC), Q(a) is a divided by 2^FB and rounded toward zero.
- R3: In rounding mode (QMODE = QM_ROUND), Q(a) = floor((a + 2^(FB−1)) / 2^FB), so an exact half rounds up.
- R4: The node error e = accV − Q(accV)·2^FB is taken before saturation, and |e| < 2^FB. The feedback term is ef = ±(e[n−1] >>> EF_SHIFT1) ± (e[n−2] >>> EF_SHIFT2), using arithmetic shifts. A sign is negative when EF_NEG1 or EF_NEG2 is set.
- R5: The node value and the output are saturated to the range [−2^(DW−1), 2^(DW−1)−1] and never wrap.
- R6: `outValid` is high in exactly the cycle after a cycle with `inValid` high, and low otherwise.
- R7: A cycle with `inValid` low changes neither the output nor any filter state. The next valid sample continues as if that cycle had not happened.
- R8: While `rstN` is low, `outValid`, `outSample`, all sum registers and both stored errors are zero.
- R9: In magnitude-truncation mode with |A1| + |A2| + 2^FB·(2^−EF_SHIFT1 + 2^−EF_SHIFT2) < 2^FB, a run of zero inputs after any history brings the output to exactly zero, and it stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | High when inSample carries a sample |
| inSample | input | DW | Signed input sample |
| outValid | output | 1 | High for one cycle when outSample is new |
| outSample | output | DW | Signed filtered output, held between samples |

## Verification
The bench builds two instances with DW = 8, CW = 8 and FB = 6. One runs in truncation mode with mild lowpass coefficients. The other runs in rounding mode with odd and negative coefficients. The small data width lets a permuted sweep apply every one of the 256 input codes to both instances, and a reference model computes each output arithmetically. Full-scale steps reach saturation within a few samples. The truncation coefficients are chosen so the R9 condition holds with margin, which makes a fixed bound on the number of zero samples before the output settles a valid check.

// File: rtl/iirPkg.sv
package iirPkg;

  typedef enum logic {
    QM_MAGTRUNC = 1'b0,
    QM_ROUND    = 1'b1
  } quantMode_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic advance;
  } iirStrobe_t;

  // Canonic signed digit of coef at position pos: -1, 0 or +1
  function automatic int csdDigit(input int coef, input int pos);
    int rem;
    int d;
    rem = coef;
    d = 0;
    for (int k = 0; k <= pos; k++) begin
      if (rem[0]) d = (rem[1:0] == 2'b01) ? 1 : -1;
      else        d = 0;
      rem = (rem - d) >>> 1;
    end
    return d;
  endfunction

endpackage

// File: rtl/iirMcm.sv
module iirMcm #(
  parameter int DW = 12,
  parameter int PW = 26,
  parameter int NDIG = 13,
  parameter int C0 = 0,
  parameter int C1 = 0,
  parameter int C2 = 0,
  parameter int C3 = 0,
  parameter int C4 = 0
) (
  input  logic signed [DW-1:0]   node,
  output logic [4:0][PW-1:0]     prod
);
  localparam int NCOEF = 5;
  localparam int COEF [NCOEF] = '{C0, C1, C2, C3, C4};

  logic signed [PW-1:0] nodeExt;
  logic signed [PW-1:0] shifted [NDIG];

  assign nodeExt = PW'(node);

  // One shared shift network feeds every coefficient chain
  for (genvar i = 0; i < NDIG; i++) begin : gShift
    assign shifted[i] = nodeExt <<< i;
  end

  for (genvar k = 0; k < NCOEF; k++) begin : gCoef
    logic signed [PW-1:0] part [NDIG+1];
    assign part[0] = '0;
    for (genvar i = 0; i < NDIG; i++) begin : gDig
      localparam int DIGIT = iirPkg::csdDigit(COEF[k], i);
      if (DIGIT > 0) begin : gAdd
        assign part[i+1] = part[i] + shifted[i];
      end else if (DIGIT < 0) begin : gSub
        assign part[i+1] = part[i] - shifted[i];
      end else begin : gPass
        assign part[i+1] = part[i];
      end
    end
    assign prod[k] = part[NDIG];
  end

endmodule

// File: rtl/iirQuant.sv
module iirQuant #(
  parameter int IW = 27,
  parameter int OW = 12,
  parameter int FB = 10,
  parameter iirPkg::quantMode_e QMODE = iirPkg::QM_MAGTRUNC
) (
  input  logic signed [IW-1:0] acc,
  output logic signed [OW-1:0] qOut,
  output logic signed [FB:0]   qErr
);
  localparam logic signed [IW-1:0] HALF  = IW'(1) <<< (FB - 1);
  localparam logic signed [IW-1:0] LOWM  = (IW'(1) <<< FB) - IW'(1);
  localparam logic signed [IW-1:0] MAXV  = IW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [IW-1:0] MINV  = -MAXV - IW'(1);

  logic signed [IW-1:0] bias;
  logic signed [IW-1:0] biased;
  logic signed [IW-1:0] qPre;

  if (QMODE == iirPkg::QM_ROUND) begin : gRound
    assign bias = HALF;
  end else begin : gTrunc
    assign bias = acc[IW-1] ? LOWM : '0;
  end

  assign biased = acc + bias;
  assign qPre   = biased >>> FB;
  // low FB bits of qPre<<FB are zero, so the error fits in FB+1 bits
  assign qErr   = acc[FB:0] - {qPre[0], {FB{1'b0}}};

  always_comb begin
    if (qPre > MAXV)      qOut = MAXV[OW-1:0];
    else if (qPre < MINV) qOut = MINV[OW-1:0];
    else                  qOut = qPre[OW-1:0];
  end

endmodule

// File: rtl/iirControl.sv
module iirControl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output iirPkg::iirStrobe_t strobe,
  output logic               outValid
);
  assign strobe.advance = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/iirDatapath.sv
module iirDatapath #(
  parameter int DW = 12,
  parameter int CW = 12,
  parameter int FB = 10,
  parameter int B0 = 256,
  parameter int B1 = 512,
  parameter int B2 = 256,
  parameter int A1 = -512,
  parameter int A2 = 256,
  parameter int EF_SHIFT1 = 3,
  parameter int EF_SHIFT2 = 4,
  parameter bit EF_NEG1 = 1'b0,
  parameter bit EF_NEG2 = 1'b0,
  parameter iirPkg::quantMode_e QMODE = iirPkg::QM_MAGTRUNC
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  iirPkg::iirStrobe_t    strobe,
  input  logic signed [DW-1:0]  inSample,
  output logic signed [DW-1:0]  outSample,
  output logic signed [FB:0]    nodeErr,
  output logic signed [FB:0]    outErr
);
  localparam int AW   = DW + CW + 3;
  localparam int PW   = DW + CW + 2;
  localparam int NDIG = CW + 1;
  localparam int EW   = FB + 1;

  logic signed [AW-1:0] s1, s2, t1, t2;
  logic signed [EW-1:0] e1, e2;
  logic signed [DW-1:0] yReg;

  logic signed [DW-1:0] node;
  logic signed [DW-1:0] yQ;
  logic [4:0][PW-1:0]   prod;
  logic signed [AW-1:0] pB0, pB1, pB2, pA1, pA2;
  logic signed [AW-1:0] xScaled, ef1, ef2, accV, accY;

  assign xScaled = AW'(inSample) <<< FB;

  if (EF_NEG1) begin : gEf1Neg
    assign ef1 = -(AW'(e1) >>> EF_SHIFT1);
  end else begin : gEf1Pos
    assign ef1 = AW'(e1) >>> EF_SHIFT1;
  end

  if (EF_NEG2) begin : gEf2Neg
    assign ef2 = -(AW'(e2) >>> EF_SHIFT2);
  end else begin : gEf2Pos
    assign ef2 = AW'(e2) >>> EF_SHIFT2;
  end

  assign accV = xScaled + s1 + ef1 + ef2;

  iirQuant #(.IW(AW), .OW(DW), .FB(FB), .QMODE(QMODE)) i_nodeQuant (
    .acc (accV),
    .qOut(node),
    .qErr(nodeErr)
  );

  iirMcm #(
    .DW(DW), .PW(PW), .NDIG(NDIG),
    .C0(B0), .C1(B1), .C2(B2), .C3(A1), .C4(A2)
  ) i_mcm (
    .node(node),
    .prod(prod)
  );

  assign pB0 = AW'($signed(prod[0]));
  assign pB1 = AW'($signed(prod[1]));
  assign pB2 = AW'($signed(prod[2]));
  assign pA1 = AW'($signed(prod[3]));
  assign pA2 = AW'($signed(prod[4]));

  assign accY = pB0 + t1;

  iirQuant #(.IW(AW), .OW(DW), .FB(FB), .QMODE(QMODE)) i_outQuant (
    .acc (accY),
    .qOut(yQ),
    .qErr(outErr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1   <= '0;
      s2   <= '0;
      t1   <= '0;
      t2   <= '0;
      e1   <= '0;
      e2   <= '0;
      yReg <= '0;
    end else if (strobe.advance) begin
      s1   <= s2 - pA1;
      s2   <= -pA2;
      t1   <= t2 + pB1;
      t2   <= pB2;
      e1   <= nodeErr;
      e2   <= e1;
      yReg <= yQ;
    end
  end

  assign outSample = yReg;

endmodule

// File: rtl/iirEfSection.sv
module iirEfSection #(
  parameter int DW = 12,
  parameter int CW = 12,
  parameter int FB = 10,
  parameter int B0 = 256,
  parameter int B1 = 512,
  parameter int B2 = 256,
  parameter int A1 = -512,
  parameter int A2 = 256,
  parameter int EF_SHIFT1 = 3,
  parameter int EF_SHIFT2 = 4,
  parameter bit EF_NEG1 = 1'b0,
  parameter bit EF_NEG2 = 1'b0,
  parameter iirPkg::quantMode_e QMODE = iirPkg::QM_MAGTRUNC
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inSample,
  output logic                 outValid,
  output logic signed [DW-1:0] outSample
);
  iirPkg::iirStrobe_t strobe;
  logic signed [FB:0] nodeErr;
  logic signed [FB:0] outErr;

  iirControl i_control (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  iirDatapath #(
    .DW(DW), .CW(CW), .FB(FB),
    .B0(B0), .B1(B1), .B2(B2), .A1(A1), .A2(A2),
    .EF_SHIFT1(EF_SHIFT1), .EF_SHIFT2(EF_SHIFT2),
    .EF_NEG1(EF_NEG1), .EF_NEG2(EF_NEG2),
    .QMODE(QMODE)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inSample (inSample),
    .outSample(outSample),
    .nodeErr  (nodeErr),
    .outErr   (outErr)
  );

endmodule

// File: rtl/iirEfChecker.sv
module iirEfChecker #(
  parameter int DW = 12,
  parameter int FB = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 outValid,
  input logic signed [DW-1:0] outSample,
  input logic signed [FB:0]   nodeErr,
  input logic signed [FB:0]   outErr
);
  localparam logic signed [FB:0] ERR_FLOOR = {1'b1, {FB{1'b0}}};

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outSample));

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rstN |=> (!outValid && outSample == '0));

  assert_node_err_R4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> nodeErr != ERR_FLOOR);

  assert_out_err_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> outErr != ERR_FLOOR);

endmodule

bind iirEfSection iirEfChecker #(.DW(DW), .FB(FB)) i_iirEfChecker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .outSample(outSample),
  .nodeErr  (nodeErr),
  .outErr   (outErr)
);

// File: tb/test_iirEfSection.sv
module test_iirEfSection;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int FB = 6;
  localparam int SH1 = 3;
  localparam int SH2 = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inSample = '0;
  logic outVT, outVR;
  logic signed [DW-1:0] outT, outR;

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;

  // model state, index 0 = truncation instance, 1 = rounding instance
  int mS1[2], mS2[2], mT1[2], mT2[2], mE1[2], mE2[2];
  int cB0[2] = '{16, 13};
  int cB1[2] = '{32, -7};
  int cB2[2] = '{16, 21};
  int cA1[2] = '{-32, -45};
  int cA2[2] = '{16, 23};
  int efActive = 0;
  int lastT = 0, lastR = 0;

  iirEfSection #(
    .DW(DW), .CW(CW), .FB(FB),
    .B0(16), .B1(32), .B2(16), .A1(-32), .A2(16),
    .EF_SHIFT1(SH1), .EF_SHIFT2(SH2),
    .QMODE(iirPkg::QM_MAGTRUNC)
  ) i_iirEfSection (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .outValid(outVT), .outSample(outT)
  );

  iirEfSection #(
    .DW(DW), .CW(CW), .FB(FB),
    .B0(13), .B1(-7), .B2(21), .A1(-45), .A2(23),
    .EF_SHIFT1(SH1), .EF_SHIFT2(SH2),
    .QMODE(iirPkg::QM_ROUND)
  ) i_iirEfSection_rnd (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .outValid(outVR), .outSample(outR)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > (1 << (DW - 1)) - 1) return (1 << (DW - 1)) - 1;
    if (v < -(1 << (DW - 1)))    return -(1 << (DW - 1));
    return v;
  endfunction

  function automatic int quantize(input int val, input bit rnd);
    if (rnd) return (val + (1 << (FB - 1))) >>> FB;
    if (val < 0) return -((-val) >> FB);
    return val >> FB;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      mS1[i] = 0; mS2[i] = 0; mT1[i] = 0; mT2[i] = 0; mE1[i] = 0; mE2[i] = 0;
    end
  endtask

  task automatic modelStep(input int idx, input int x, output int y);
    int ef, accV, q, err, v, accY;
    ef = (mE1[idx] >>> SH1) + (mE2[idx] >>> SH2);
    if (idx == 0 && ef != 0) efActive++;
    accV = x * (1 << FB) + mS1[idx] + ef;
    q = quantize(accV, idx == 1);
    err = accV - q * (1 << FB);
    v = sat(q);
    accY = cB0[idx] * v + mT1[idx];
    y = sat(quantize(accY, idx == 1));
    mS1[idx] = mS2[idx] - cA1[idx] * v;
    mS2[idx] = -cA2[idx] * v;
    mT1[idx] = mT2[idx] + cB1[idx] * v;
    mT2[idx] = cB2[idx] * v;
    mE2[idx] = mE1[idx];
    mE1[idx] = err;
  endtask

  task automatic push(input bit vld, input int x, input string tag);
    int yT, yR;
    @(negedge clk);
    inValid = vld;
    inSample = x[DW-1:0];
    @(posedge clk);
    #1;
    if (vld) begin
      modelStep(0, x, yT);
      modelStep(1, x, yR);
      chk({tag, " R2 trunc"}, int'(outT), yT);
      chk({tag, " R3 round"}, int'(outR), yR);
      chk("R6 valid after sample", int'(outVT), 1);
    end else begin
      chk("R6 idle valid", int'(outVT), 0);
      chk("R7 hold trunc", int'(outT), lastT);
      chk("R7 hold round", int'(outR), lastR);
    end
    lastT = int'(outT);
    lastR = int'(outR);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    @(posedge clk);
    #1;
    chk("R8 reset valid", int'(outVT), 0);
    chk("R8 reset out trunc", int'(outT), 0);
    chk("R8 reset out round", int'(outR), 0);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    lastT = 0;
    lastR = 0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int zeroRun;
    modelReset();
    repeat (3) @(posedge clk);
    doReset();

    // R1: every input code once, permuted
    for (int i = 0; i < 256; i++) push(1'b1, ((i * 77) & 255) - 128, "R1 sweep");
    chk("R4 error feedback engaged", int'(efActive > 0), 1);

    // R7: gaps between valid samples with junk on the input
    for (int i = 0; i < 40; i++) push(i % 3 != 0, ((i * 53) & 255) - 128, "R1 gaps");

    // R5: full-scale steps
    for (int i = 0; i < 12; i++) push(1'b1, 127, "R1 step");
    chk("R5 positive saturation", int'(outT), 127);
    for (int i = 0; i < 12; i++) push(1'b1, -128, "R1 step");
    chk("R5 negative saturation", int'(outT), -128);

    // R9: zero input after a large burst
    for (int i = 0; i < 8; i++) push(1'b1, (i % 2) ? -128 : 127, "R1 burst");
    zeroRun = 0;
    for (int i = 0; i < 80; i++) begin
      push(1'b1, 0, "R1 zero");
      if (outT == 0) zeroRun++;
      else zeroRun = 0;
    end
    chk("R9 zero-input decay run", int'(zeroRun >= 10), 1);
    chk("R9 final output", int'(outT), 0);

    // R8: reset mid-stream, then state must restart from zero
    for (int i = 0; i < 5; i++) push(1'b1, 90 - 40 * i, "R1 pre-reset");
    doReset();
    for (int i = 0; i < 30; i++) push(1'b1, ((i * 29) & 255) - 128, "R8 after reset");

    finishRun();
  end

endmodule